// File: doc/BRIEF.md
# Threshold Timer with Selectable Interrupt Style

This block is a 16-bit up-counter. It advances on events from one of two sources. The external source is an asynchronous count pin. It passes through a two-flop synchronizer, and then an edge detector picks out its active edge. The internal source is a synchronous tick strobe that advances the counter once for every clock cycle it is high. Each event is compared against a programmable threshold. When the incremented count equals the threshold, the block raises an interrupt.

In cyclic mode a match reloads the counter to zero and counting carries on, so the period is the threshold value in events. In one-shot mode the counter stops at the threshold and ignores further events until a restart pulse. The interrupt can be a one-cycle pulse for each match, or a level that stays high until a clear input. The threshold can be rewritten at any time; a write lands at the clock edge, so the comparison made in that same cycle still uses the old value. The count value is always visible on an output port, and reading it has no side effects. The external pin must toggle no faster than one quarter of the clock rate.

Top module: `thresh_timer`

## Requirements
- R1: After reset, `count` is 0, `irq` is 0 and `halted` is 0.
- R2: With `src_ext`=1, `edge_fall`=0 counts rising edges of `ext_cnt_in`, and `edge_fall`=1 counts falling edges; the other edge leaves `count` unchanged. The count updates at the third rising clock edge after the pin change is first sampled.
- R3: With `src_ext`=0, each clock edge that samples `int_tick` high is one event and `ext_cnt_in` is ignored. With `src_ext`=1, `int_tick` is ignored.
- R4: While `cnt_en`=0, events do not change `count`.
- R5: In cyclic mode (`one_shot`=0), an event whose incremented count equals the threshold is a match, and `count` becomes 0 at that clock edge; other events add one.
- R6: In one-shot mode (`one_shot`=1), a match leaves `count` equal to the threshold and sets `halted`; later events do not change `count` until a restart.
- R7: With `irq_level`=0, `irq` is high for exactly the one cycle after the edge at which a match occurred.
- R8: With `irq_level`=1, `irq` rises at a match and stays high until a cycle with `irq_clr`=1 and no match; a match in the same cycle as `irq_clr` keeps `irq` high.
- R9: `thr_wr`=1 loads `thr_wdata` as the threshold at the clock edge. An event in the same cycle as the write is compared against the previous threshold, and later events use the new one.
- R10: If the threshold is set below the current count in cyclic mode, the counter runs on to 0xFFFF, wraps to 0 without a match, and matches only when it next reaches the threshold.
- R11: `restart`=1 sets `count` to 0 and clears `halted` at the next edge, and it takes priority over a coincident event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cnt_en | input | 1 | Counting enable |
| src_ext | input | 1 | 1 selects the external pin, 0 the internal tick |
| edge_fall | input | 1 | Active-edge polarity for the external pin, 1 = falling |
| ext_cnt_in | input | 1 | Asynchronous external count pin |
| int_tick | input | 1 | Synchronous internal count strobe |
| one_shot | input | 1 | 1 = halt after a match, 0 = reload to zero |
| irq_level | input | 1 | 1 = held interrupt, 0 = one-cycle pulse |
| restart | input | 1 | Clears the count and the halt |
| thr_wr | input | 1 | Threshold write strobe |
| thr_wdata | input | 16 | New threshold value |
| irq_clr | input | 1 | Clears a held interrupt |
| count | output | 16 | Current count |
| halted | output | 1 | One-shot run finished |
| irq | output | 1 | Interrupt request |

## Verification
A threshold write and a count event can land in the same clock cycle. The bench provokes this by raising `int_tick` and `thr_wr` together, after the count has been brought to one below the old threshold. The result is judged by that event matching the old threshold: `count` goes to 0 and `irq` is raised. The counter then runs to the new threshold and matches there. The bench also makes a match and `irq_clr` coincide, and checks that the held interrupt survives.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  // Action selected by the counter core for the coming edge
  typedef enum logic [1:0] {
    ACT_HOLD   = 2'd0,
    ACT_STEP   = 2'd1,
    ACT_RELOAD = 2'd2,
    ACT_STOP   = 2'd3
  } cnt_act_e;

endpackage

// File: rtl/tmr_evt_sel.sv
module tmr_evt_sel #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic src_ext,
  input  logic edge_fall,
  input  logic ext_cnt_in,
  input  logic int_tick,
  output logic evt
);

  localparam int MSB = SYNC_STAGES - 1;

  logic [MSB:0] sync_q;
  logic [MSB:0] sync_d;
  logic         last_q;
  logic         last_d;
  logic         ext_edge;

  // Polarity folded in ahead of the synchronizer, so only a rising edge is detected
  always_comb begin
    sync_d = {sync_q[MSB-1:0], ext_cnt_in ^ edge_fall};
    last_d = sync_q[MSB];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      last_q <= last_d;
    end
  end

  always_comb begin
    ext_edge = sync_q[MSB] & ~last_q;
    evt      = src_ext ? ext_edge : int_tick;
  end

endmodule

// File: rtl/tmr_cnt_core.sv
module tmr_cnt_core
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic             one_shot,
  input  logic             restart,
  input  logic             evt,
  input  logic             thr_wr,
  input  logic [CNT_W-1:0] thr_wdata,
  output logic [CNT_W-1:0] count,
  output logic             halted,
  output logic             match
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] thr_q, thr_d;
  logic             halt_q, halt_d;
  logic [CNT_W-1:0] cnt_inc;
  logic             adv;
  logic             hit;
  cnt_act_e         act;

  always_comb begin
    cnt_inc = cnt_q + 1'b1;
    adv     = evt & cnt_en & ~halt_q & ~restart;
    hit     = (cnt_inc == thr_q);
    match   = adv & hit;
    if (!adv)          act = ACT_HOLD;
    else if (!hit)     act = ACT_STEP;
    else if (one_shot) act = ACT_STOP;
    else               act = ACT_RELOAD;
  end

  always_comb begin
    cnt_d  = cnt_q;
    halt_d = halt_q;
    thr_d  = thr_wr ? thr_wdata : thr_q;
    if (restart) begin
      cnt_d  = '0;
      halt_d = 1'b0;
    end else begin
      unique case (act)
        ACT_STEP:   cnt_d = cnt_inc;
        ACT_RELOAD: cnt_d = '0;
        ACT_STOP: begin
          cnt_d  = cnt_inc;
          halt_d = 1'b1;
        end
        default:    cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      halt_q <= 1'b0;
      thr_q  <= '0;
    end else begin
      cnt_q  <= cnt_d;
      halt_q <= halt_d;
      thr_q  <= thr_d;
    end
  end

  assign count  = cnt_q;
  assign halted = halt_q;

  // R4
  en_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en && !restart) |=> $stable(cnt_q));

  // R6
  oneshot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_q && !restart) |=> $stable(cnt_q));

  // R6
  oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (match && one_shot) |=> halt_q);

  // R5
  cyc_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (match && !one_shot) |=> (cnt_q == '0));

  // R11
  restart_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == '0 && !halt_q));

endmodule

// File: rtl/tmr_irq_out.sv
module tmr_irq_out (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_level,
  input  logic match,
  input  logic irq_clr,
  output logic irq
);

  logic irq_q, irq_d;

  // Set wins over clear in held mode; pulse mode follows the match only
  always_comb begin
    if (irq_level) irq_d = match | (irq_q & ~irq_clr);
    else           irq_d = match;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq = irq_q;

  // R8
  lvl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_level && irq_q && !irq_clr) |=> irq_q);

  // R8
  lvl_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_level && irq_clr && !match) |=> !irq_q);

  // R8
  set_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> irq_q);

  // R7
  pulse_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_level && !match) |=> !irq_q);

endmodule

// File: rtl/thresh_timer.sv
module thresh_timer #(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic             src_ext,
  input  logic             edge_fall,
  input  logic             ext_cnt_in,
  input  logic             int_tick,
  input  logic             one_shot,
  input  logic             irq_level,
  input  logic             restart,
  input  logic             thr_wr,
  input  logic [CNT_W-1:0] thr_wdata,
  input  logic             irq_clr,
  output logic [CNT_W-1:0] count,
  output logic             halted,
  output logic             irq
);

  logic evt;
  logic match;

  tmr_evt_sel #(.SYNC_STAGES(SYNC_STAGES)) i_evt (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_ext    (src_ext),
    .edge_fall  (edge_fall),
    .ext_cnt_in (ext_cnt_in),
    .int_tick   (int_tick),
    .evt        (evt)
  );

  tmr_cnt_core #(.CNT_W(CNT_W)) i_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt_en    (cnt_en),
    .one_shot  (one_shot),
    .restart   (restart),
    .evt       (evt),
    .thr_wr    (thr_wr),
    .thr_wdata (thr_wdata),
    .count     (count),
    .halted    (halted),
    .match     (match)
  );

  tmr_irq_out i_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_level (irq_level),
    .match     (match),
    .irq_clr   (irq_clr),
    .irq       (irq)
  );

endmodule

// File: tb/test_thresh_timer.sv
module test_thresh_timer;

  logic        clk;
  logic        rst_n;
  logic        cnt_en, src_ext, edge_fall, ext_cnt_in, int_tick;
  logic        one_shot, irq_level, restart, thr_wr, irq_clr;
  logic [15:0] thr_wdata;
  logic [15:0] count;
  logic        halted, irq;

  int checks = 0;
  int errors = 0;

  thresh_timer i_thresh_timer (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .src_ext(src_ext),
    .edge_fall(edge_fall), .ext_cnt_in(ext_cnt_in), .int_tick(int_tick),
    .one_shot(one_shot), .irq_level(irq_level), .restart(restart),
    .thr_wr(thr_wr), .thr_wdata(thr_wdata), .irq_clr(irq_clr),
    .count(count), .halted(halted), .irq(irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_cnt(input string req, input int exp);
    chk(count == exp, req, count, exp);
  endtask

  task automatic ticks(input int n);
    @(negedge clk) int_tick = 1'b1;
    repeat (n) @(posedge clk);
    @(negedge clk) int_tick = 1'b0;
  endtask

  task automatic set_pin(input logic v);
    @(negedge clk) ext_cnt_in = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic wr_thr(input int v);
    @(negedge clk) begin thr_wr = 1'b1; thr_wdata = v[15:0]; end
    @(negedge clk) thr_wr = 1'b0;
  endtask

  task automatic pulse_restart;
    @(negedge clk) restart = 1'b1;
    @(negedge clk) restart = 1'b0;
  endtask

  task automatic pulse_clr;
    @(negedge clk) irq_clr = 1'b1;
    @(negedge clk) irq_clr = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk_cnt("R1 count", 0);
    chk(irq == 1'b0, "R1 irq", irq, 0);
    chk(halted == 1'b0, "R1 halted", halted, 0);
  endtask

  task automatic t_ext_polarity;
    src_ext = 1'b1; edge_fall = 1'b0; cnt_en = 1'b1;
    wr_thr(1000); pulse_restart();
    set_pin(1'b1);
    chk_cnt("R2 rising counted", 1);
    set_pin(1'b0);
    chk_cnt("R2 falling ignored", 1);
    ticks(3);
    chk_cnt("R3 tick ignored on ext", 1);
    @(negedge clk) begin cnt_en = 1'b0; edge_fall = 1'b1; end
    repeat (5) @(negedge clk);
    pulse_restart();
    @(negedge clk) cnt_en = 1'b1;
    set_pin(1'b1);
    chk_cnt("R2 rising ignored when falling selected", 0);
    set_pin(1'b0);
    chk_cnt("R2 falling counted", 1);
  endtask

  task automatic t_int_source;
    @(negedge clk) begin cnt_en = 1'b0; src_ext = 1'b0; edge_fall = 1'b0; end
    repeat (5) @(negedge clk);
    pulse_restart();
    @(negedge clk) cnt_en = 1'b1;
    ticks(5);
    chk_cnt("R3 internal ticks", 5);
    set_pin(1'b1);
    set_pin(1'b0);
    chk_cnt("R3 pin ignored on internal", 5);
    @(negedge clk) cnt_en = 1'b0;
    ticks(4);
    chk_cnt("R4 disabled", 5);
    @(negedge clk) cnt_en = 1'b1;
  endtask

  task automatic t_cyclic_pulse;
    one_shot = 1'b0; irq_level = 1'b0;
    wr_thr(3); pulse_restart();
    ticks(2);
    chk_cnt("R5 below threshold", 2);
    chk(irq == 1'b0, "R7 no irq yet", irq, 0);
    @(negedge clk) int_tick = 1'b1;
    @(posedge clk);
    @(negedge clk) int_tick = 1'b0;
    chk_cnt("R5 reload to zero", 0);
    chk(irq == 1'b1, "R7 pulse high", irq, 1);
    @(negedge clk);
    chk(irq == 1'b0, "R7 pulse one cycle", irq, 0);
    ticks(5);
    chk_cnt("R5 continues after reload", 2);
  endtask

  task automatic t_oneshot;
    one_shot = 1'b1; irq_level = 1'b1;
    wr_thr(4); pulse_restart();
    ticks(4);
    chk_cnt("R6 stops at threshold", 4);
    chk(halted == 1'b1, "R6 halted", halted, 1);
    chk(irq == 1'b1, "R8 held irq", irq, 1);
    ticks(3);
    chk_cnt("R6 ignores events", 4);
    repeat (5) @(negedge clk);
    chk(irq == 1'b1, "R8 still held", irq, 1);
    pulse_clr();
    chk(irq == 1'b0, "R8 cleared", irq, 0);
    pulse_restart();
    chk_cnt("R11 restart count", 0);
    chk(halted == 1'b0, "R11 restart halt", halted, 0);
    ticks(2);
    chk_cnt("R11 counts after restart", 2);
  endtask

  task automatic t_level_race;
    one_shot = 1'b0; irq_level = 1'b1;
    wr_thr(2); pulse_restart();
    ticks(1);
    @(negedge clk) begin int_tick = 1'b1; irq_clr = 1'b1; end
    @(posedge clk);
    @(negedge clk) begin int_tick = 1'b0; irq_clr = 1'b0; end
    chk(irq == 1'b1, "R8 match beats clear", irq, 1);
    pulse_clr();
    chk(irq == 1'b0, "R8 clear", irq, 0);
  endtask

  task automatic t_restart_prio;
    one_shot = 1'b0;
    wr_thr(100); pulse_restart();
    ticks(7);
    @(negedge clk) begin int_tick = 1'b1; restart = 1'b1; end
    @(negedge clk) begin int_tick = 1'b0; restart = 1'b0; end
    chk_cnt("R11 restart beats event", 0);
  endtask

  task automatic t_thr_update;
    one_shot = 1'b0; irq_level = 1'b1;
    wr_thr(4); pulse_restart(); pulse_clr();
    ticks(3);
    chk_cnt("R9 setup", 3);
    @(negedge clk) begin int_tick = 1'b1; thr_wr = 1'b1; thr_wdata = 16'd10; end
    @(posedge clk);
    @(negedge clk) begin int_tick = 1'b0; thr_wr = 1'b0; end
    chk_cnt("R9 old threshold used", 0);
    chk(irq == 1'b1, "R9 old threshold irq", irq, 1);
    pulse_clr();
    ticks(9);
    chk_cnt("R9 new threshold not yet", 9);
    chk(irq == 1'b0, "R9 no early irq", irq, 0);
    ticks(1);
    chk_cnt("R9 new threshold match", 0);
    chk(irq == 1'b1, "R9 new threshold irq", irq, 1);
    pulse_clr();
  endtask

  task automatic t_wrap;
    one_shot = 1'b0; irq_level = 1'b1;
    wr_thr(100); pulse_restart(); pulse_clr();
    ticks(50);
    wr_thr(20);
    ticks(65485);
    chk_cnt("R10 reaches top", 65535);
    chk(irq == 1'b0, "R10 no irq before wrap", irq, 0);
    ticks(1);
    chk_cnt("R10 wraps to zero", 0);
    chk(irq == 1'b0, "R10 wrap is no match", irq, 0);
    ticks(19);
    chk_cnt("R10 below threshold", 19);
    ticks(1);
    chk_cnt("R10 match after wrap", 0);
    chk(irq == 1'b1, "R10 irq after wrap", irq, 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cnt_en = 1'b0; src_ext = 1'b0; edge_fall = 1'b0;
    ext_cnt_in = 1'b0; int_tick = 1'b0; one_shot = 1'b0; irq_level = 1'b0;
    restart = 1'b0; thr_wr = 1'b0; thr_wdata = '0; irq_clr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_ext_polarity();
    t_int_source();
    t_cyclic_pulse();
    t_oneshot();
    t_level_race();
    t_restart_prio();
    t_thr_update();
    t_wrap();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule